// File: doc/BRIEF.md
# Serial Register Access Port

A slave-side serial port that gives a host read and write access to an internal bank of 64 eight-bit registers. The host uses four wires: an active-low select, a shift clock, serial data in and serial data out. Each transfer opens with a direction bit and a 6-bit register address. Eight data bits follow. A write loads the received byte into the addressed register. A read shifts the stored byte back out on the data-out line.

The shift clock is slow compared with the block's system clock. The port oversamples select, shift clock and data in through a two-stage synchronizer and then detects the clock edges. A run-time configuration input chooses which shift-clock edge launches outgoing read data. A separate output-enable tells the pad when to drive. The enable stays low for all of a write and for the command and address part of a read.

Top module: `ser_reg_port`

## Requirements
- R1: Serial input is taken on rising shift-clock edges. Each transfer carries, in order: one direction bit (1 = read, 0 = write), six address bits MSB first, and eight data bits MSB first. Each rising edge inside a selected transfer advances the bit position by one.
- R2: With `out_edge_i` = 0, read data is launched on rising edges. The data MSB appears after the rising edge that takes the last address bit, and each following rising edge presents the next bit. With `out_edge_i` = 1, read data is launched on falling edges, and the MSB appears after the falling edge that follows that rising edge. Between launches `sdo_o` holds its value.
- R3: `sdo_oe_o` stays low for the whole of every write transfer.
- R4: During a read, `sdo_oe_o` stays low while the direction and address bits are received. It is high from the first data launch until select is released.
- R5: A write changes its register only after the 15th bit is received. A transfer that is ended early leaves every register unchanged.
- R6: Releasing `cs_ni` drops `sdo_oe_o` and clears the bit position, so the next transfer is framed from its direction bit.
- R7: After reset every register reads 0x00, and a read returns the last byte written to that address.
- R8: Shift-clock edges after the 15th bit of a transfer cause no further write and do not alter the register that was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the serial lines |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Transfer select, active low |
| sck_i | input | 1 | Host shift clock |
| sdi_i | input | 1 | Serial data from the host |
| out_edge_i | input | 1 | Launch edge for read data: 0 rising, 1 falling |
| sdo_o | output | 1 | Serial read data to the host (0 when not enabled) |
| sdo_oe_o | output | 1 | Output enable for the data-out pad |

## Verification
The assertions check several properties on every cycle. The bit position advances on each rising edge inside a transfer. The output enable never rises during a write or before the address is complete, and it falls once select is released. The outgoing shift register holds still between launches. Two things can only be shown by the bench's transfers: that the right byte reaches the right register, and that the two launch-edge settings put each data bit on the line at the expected half of the shift clock. The bench also covers aborted transfers, surplus clock edges and reset contents.

// File: rtl/ser_reg_pkg.sv
package ser_reg_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int SYNC_STAGES = 2;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } launch_edge_e;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= RST_VAL;
      else if (g == 0) stg_q[g] <= d_i;
      else stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ser_frame.sv
module ser_frame #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  localparam int TOTAL = 1 + ADDR_W + DATA_W,
  localparam int CNT_W = $clog2(TOTAL + 1),
  localparam int SR_W = (DATA_W > ADDR_W) ? DATA_W : ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_s_i,
  input  logic              sck_s_i,
  input  logic              sdi_s_i,
  output logic              active_o,
  output logic              rise_o,
  output logic              fall_o,
  output logic              rw_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam logic [CNT_W-1:0] C_TOTAL = CNT_W'(TOTAL);
  localparam logic [CNT_W-1:0] C_LAST_ADDR = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] C_LAST_BIT = CNT_W'(TOTAL - 1);

  logic             sck_prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SR_W-1:0]  in_sr_q;
  logic             rw_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_now;

  assign active_o = ~cs_n_s_i;
  assign rise_o   = sck_s_i & ~sck_prev_q;
  assign fall_o   = ~sck_s_i & sck_prev_q;
  assign addr_now = {in_sr_q[ADDR_W-2:0], sdi_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_prev_q <= 1'b0;
      cnt_q      <= '0;
      in_sr_q    <= '0;
      rw_q       <= 1'b0;
      addr_q     <= '0;
    end else begin
      sck_prev_q <= sck_s_i;
      if (!active_o) begin
        cnt_q <= '0;
      end else if (rise_o && cnt_q < C_TOTAL) begin
        cnt_q   <= cnt_q + 1'b1;
        in_sr_q <= {in_sr_q[SR_W-2:0], sdi_s_i};
        if (cnt_q == '0) rw_q <= sdi_s_i;
        if (cnt_q == C_LAST_ADDR) addr_q <= addr_now;
      end
    end
  end

  // rising-launch reads need the address in the same cycle it completes
  assign addr_o  = (rise_o && cnt_q == C_LAST_ADDR) ? addr_now : addr_q;
  assign rw_o    = rw_q;
  assign cnt_o   = cnt_q;
  assign wr_en_o = active_o && rise_o && (cnt_q == C_LAST_BIT) && !rw_q;
  assign wdata_o = {in_sr_q[DATA_W-2:0], sdi_s_i};

  assert_bit_advance_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && rise_o && cnt_q < C_TOTAL) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/ser_out.sv
module ser_out #(
  parameter int DATA_W = 8,
  parameter int CNT_W = 4,
  parameter int LAST_ADDR = 6,
  parameter int LAST_BIT = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              edge_sel_i,
  input  logic              rw_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              sdo_o,
  output logic              oe_o
);
  import ser_reg_pkg::*;

  // rising launch sees the pre-increment count, falling launch the post-increment one
  localparam logic [CNT_W-1:0] C_LOAD_R = CNT_W'(LAST_ADDR);
  localparam logic [CNT_W-1:0] C_LOAD_F = CNT_W'(LAST_ADDR + 1);
  localparam logic [CNT_W-1:0] C_SH_R_LO = CNT_W'(LAST_ADDR + 1);
  localparam logic [CNT_W-1:0] C_SH_R_HI = CNT_W'(LAST_BIT - 1);
  localparam logic [CNT_W-1:0] C_SH_F_LO = CNT_W'(LAST_ADDR + 2);
  localparam logic [CNT_W-1:0] C_SH_F_HI = CNT_W'(LAST_BIT);

  logic              drv_q;
  logic [DATA_W-1:0] out_sr_q;
  logic              launch, load, shift;
  logic [CNT_W-1:0]  load_cnt, sh_lo, sh_hi;

  always_comb begin
    if (launch_edge_e'(edge_sel_i) == EDGE_FALL) begin
      launch = fall_i; load_cnt = C_LOAD_F; sh_lo = C_SH_F_LO; sh_hi = C_SH_F_HI;
    end else begin
      launch = rise_i; load_cnt = C_LOAD_R; sh_lo = C_SH_R_LO; sh_hi = C_SH_R_HI;
    end
  end

  assign load  = active_i && launch && rw_i && !drv_q && (cnt_i == load_cnt);
  assign shift = active_i && launch && drv_q && (cnt_i >= sh_lo) && (cnt_i <= sh_hi);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_q    <= 1'b0;
      out_sr_q <= '0;
    end else begin
      if (!active_i) drv_q <= 1'b0;
      else if (load) drv_q <= 1'b1;
      if (load) out_sr_q <= rdata_i;
      else if (shift) out_sr_q <= {out_sr_q[DATA_W-2:0], 1'b0};
    end
  end

  assign oe_o  = drv_q;
  assign sdo_o = drv_q & out_sr_q[DATA_W-1];

  assert_no_drive_on_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_q |-> rw_i);
  assert_float_in_header_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_q |-> (cnt_i > C_LOAD_R));
  assert_release_floats_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !drv_q);
  assert_hold_between_launch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_q && !launch) |=> $stable(out_sr_q));
endmodule

// File: rtl/ser_bank.sv
module ser_bank #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port
  import ser_reg_pkg::*;
#(
  parameter int A_W = ADDR_W,
  parameter int D_W = DATA_W,
  parameter int SYNC_N = SYNC_STAGES,
  localparam int TOTAL = 1 + A_W + D_W,
  localparam int CNT_W = $clog2(TOTAL + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic sdi_i,
  input  logic out_edge_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  logic [2:0]       sync_q;
  logic             active, rise, fall, rw, wr_en;
  logic [CNT_W-1:0] cnt;
  logic [A_W-1:0]   addr;
  logic [D_W-1:0]   wdata, rdata;

  ser_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b100)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({cs_ni, sck_i, sdi_i}), .q_o(sync_q)
  );

  ser_frame #(.ADDR_W(A_W), .DATA_W(D_W)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cs_n_s_i(sync_q[2]), .sck_s_i(sync_q[1]), .sdi_s_i(sync_q[0]),
    .active_o(active), .rise_o(rise), .fall_o(fall), .rw_o(rw), .cnt_o(cnt),
    .addr_o(addr), .wr_en_o(wr_en), .wdata_o(wdata)
  );

  ser_bank #(.ADDR_W(A_W), .DATA_W(D_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_en), .waddr_i(addr),
    .wdata_i(wdata), .raddr_i(addr), .rdata_o(rdata)
  );

  ser_out #(.DATA_W(D_W), .CNT_W(CNT_W), .LAST_ADDR(A_W), .LAST_BIT(TOTAL - 1)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active), .rise_i(rise), .fall_i(fall),
    .edge_sel_i(out_edge_i), .rw_i(rw), .cnt_i(cnt), .rdata_i(rdata),
    .sdo_o(sdo_o), .oe_o(sdo_oe_o)
  );

  assert_write_while_float_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> !sdo_oe_o);
endmodule

// File: tb/sim_ser_reg_port.sv
module sim_ser_reg_port;
  localparam int H = 8;
  localparam int NV = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, edge_sel = 1'b0;
  logic sdo, sdo_oe;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ser_reg_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .out_edge_i(edge_sel), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  // {rw, edge, addr[5:0], data[7:0]}; for reads data is the expected value
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 1'b0, 6'h00, 8'hA5}, {1'b1, 1'b0, 6'h00, 8'hA5},
    {1'b0, 1'b1, 6'h3F, 8'h3C}, {1'b1, 1'b1, 6'h3F, 8'h3C},
    {1'b0, 1'b0, 6'h15, 8'h81}, {1'b1, 1'b1, 6'h15, 8'h81},
    {1'b1, 1'b0, 6'h15, 8'h81}, {1'b1, 1'b1, 6'h2A, 8'h00},
    {1'b0, 1'b1, 6'h01, 8'h7E}, {1'b1, 1'b0, 6'h01, 8'h7E}
  };

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // sends nbits; bits past 15 are ones; collects read bits and counts enable timing errors
  task automatic xfer(input logic rw, input logic es, input logic [5:0] a,
                      input logic [7:0] d, input int nbits,
                      output logic [7:0] rd, output int oe_bad);
    logic [14:0] fr;
    fr = {rw, a, d};
    rd = '0;
    oe_bad = 0;
    edge_sel = es;
    cs_n = 1'b0;
    wclk(H);
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b0;
      sdi = (i < 15) ? fr[14-i] : 1'b1;
      wclk(H);
      if ((i <= 6 || !rw) && sdo_oe !== 1'b0) oe_bad++;
      sck = 1'b1;
      wclk(H);
      if (!rw) begin
        if (sdo_oe !== 1'b0) oe_bad++;
      end else if (!es) begin
        if (i >= 6 && i <= 13) begin
          if (sdo_oe !== 1'b1) oe_bad++;
          rd[13-i] = sdo;
        end
      end else begin
        if (i == 6 && sdo_oe !== 1'b0) oe_bad++;
        if (i >= 7 && i <= 14) begin
          if (sdo_oe !== 1'b1) oe_bad++;
          rd[14-i] = sdo;
        end
      end
    end
    sck = 1'b0;
    wclk(H);
    cs_n = 1'b1;
    wclk(H);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int bad;
    wclk(3);
    // reset state: R7 registers cleared, output floating
    check("R4 reset oe", {31'd0, sdo_oe}, 32'd0);
    check("R4 reset sdo", {31'd0, sdo}, 32'd0);
    rst_n = 1'b1;
    wclk(4);

    for (int v = 0; v < NV; v++) begin
      xfer(VEC[v][15], VEC[v][14], VEC[v][13:8], VEC[v][7:0], 15, rd, bad);
      if (VEC[v][15]) begin
        check(VEC[v][14] ? "R1,R2,R7 read falling" : "R1,R2,R7 read rising",
              {24'd0, rd}, {24'd0, VEC[v][7:0]});
        check("R2,R4 read enable timing", bad, 0);
      end else begin
        check("R3 write enable low", bad, 0);
      end
    end

    // R5: aborted write leaves the register at its reset value
    xfer(1'b0, 1'b0, 6'h10, 8'hFF, 10, rd, bad);
    check("R5 abort no drive", bad, 0);
    xfer(1'b1, 1'b0, 6'h10, 8'h00, 15, rd, bad);
    check("R5 aborted write ignored", {24'd0, rd}, 32'h00);

    // R8: surplus clocks after the 15th bit
    xfer(1'b0, 1'b1, 6'h20, 8'h5A, 23, rd, bad);
    check("R8 surplus clocks no drive", bad, 0);
    xfer(1'b1, 1'b0, 6'h20, 8'h00, 15, rd, bad);
    check("R8 surplus clocks no rewrite", {24'd0, rd}, 32'h5A);

    // R6: release select in the middle of a read data phase
    xfer(1'b1, 1'b0, 6'h00, 8'h00, 10, rd, bad);
    check("R6 enable dropped after release", {31'd0, sdo_oe}, 32'd0);
    xfer(1'b1, 1'b1, 6'h3F, 8'h00, 15, rd, bad);
    check("R6 framing restarts", {24'd0, rd}, 32'h3C);
    check("R6 enable timing after abort", bad, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule